// File: doc/BRIEF.md
# Programmable-Timing Static Memory Controller

This block runs one read or write cycle on an external asynchronous static memory (SRAM or NOR flash) for each request it accepts. It drives an active-low chip select, output enable, write enable and a per-byte mask. It splits each cycle into an address-setup phase, an access phase and a trailing recovery gap. The length of each phase comes from a 4-bit count in a 32-bit timing word. A count of n gives n+1 clocks.

The timing word and a 3-bit mode word arrive as plain configuration inputs. The controller copies both into shadow registers at the moment it accepts a request, so a rewrite during a memory cycle leaves that cycle unchanged. The mode word can select a page read for burst-capable flash. It can also turn off the write-enable strobe so that the byte mask acts as the write strobe, and it can drive the byte mask during reads. When a request finishes, a one-clock completion pulse goes out together with the read data.

Top module: `smc_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, every strobe is high (inactive), the byte mask is all ones, `req_ready` is 1, and both `done` and `cfg_err` are 0.
- R2: A read that is not a page read holds the chip select low for the setup phase and then for the access phase. The setup phase lasts timing[7:4]+1 clocks with output enable high. The access phase lasts timing[3:0]+1 clocks with output enable low. Write enable stays high throughout, and the write data bus is not driven.
- R3: A write holds the chip select low and drives the write data for the setup phase and then the access phase. The setup phase lasts timing[23:20]+1 clocks with write enable high. The access phase lasts timing[19:16]+1 clocks. Write enable is low during the first timing[27:24]+1 access clocks, cut short at the end of the access phase, and output enable stays high.
- R4: A write setup count of 1111 gives a 15-clock setup phase. Accepting such a write sets `cfg_err` from the next clock, and `cfg_err` stays set until reset.
- R5: After each access phase comes a gap of timing[31:28]+1 clocks after a write, or timing[15:12]+1 clocks after a read. In the gap all strobes are inactive. `req_ready` is 1 only when the controller is idle, and a request presented while it is 0 is ignored.
- R6: With mode bit 0 set, a read has no setup phase. Chip select and output enable go low together in the first clock. The access lasts timing[11:8]+1 clocks unless the previous accepted request was also a page read whose address shared bits [AW-1:PAGE_W] with this one. In that case it lasts timing[3:0]+1 clocks.
- R7: With mode bit 1 set, write enable stays high on writes. The byte mask carries ~`req_be` only during the write-enable window of R3 and is all ones for the rest of the write.
- R8: With mode bit 1 clear, the byte mask carries ~`req_be` for the whole write access phase and is all ones during the setup phase.
- R9: During a read access the byte mask carries ~`req_be` when mode bit 2 is set, and is all ones when it is clear.
- R10: `done` is high for exactly one clock, the first clock of the gap. After a read, `rd_data` then holds the value `mem_rdata` had in the last access clock.
- R11: A request uses the timing and mode words present in the clock it was accepted. Changes to them afterwards do not affect that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_timing | input | 32 | Timing word: [31:28] write gap, [27:24] write-enable window, [23:20] write setup, [19:16] write access, [15:12] read gap, [11:8] first page read, [7:4] read setup, [3:0] read access |
| cfg_mode | input | 3 | Bit 0 page read, bit 1 write-enable off, bit 2 byte mask on reads |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_be | input | BW | Byte enables, active high |
| req_ready | output | 1 | Controller idle, request will be accepted |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Read data captured in the last access clock |
| cfg_err | output | 1 | Sticky flag for a prohibited write setup count |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_wdata_oe | output | 1 | Drive enable for the memory data bus |
| mem_rdata | input | DW | Memory read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bm_n | output | BW | Byte mask, active low |

## Verification
Two things can happen in the same clock as a request being accepted: the configuration words can be rewritten, and a new request can be presented while the controller is busy. The bench provokes both. While a cycle is in progress it presents a random request and random timing and mode words on every busy clock. The reference model then requires the busy cycle's phase lengths, strobes and masks to follow only the words that were latched when the request was accepted. It also requires that none of the busy-time requests is taken, which R11 and R5 judge at the pins.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] w_idle;
        logic [CNT_W-1:0] w_we;
        logic [CNT_W-1:0] w_setup;
        logic [CNT_W-1:0] w_acc;
        logic [CNT_W-1:0] r_idle;
        logic [CNT_W-1:0] r_first;
        logic [CNT_W-1:0] r_setup;
        logic [CNT_W-1:0] r_acc;
    } timing_t;

    typedef struct packed {
        logic rd_mask;
        logic we_off;
        logic page;
    } mode_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2,
        PH_GAP    = 2'd3
    } phase_e;

    localparam timing_t          TIMING_RST = timing_t'(32'h055F_F00F);
    localparam mode_t            MODE_RST   = mode_t'(3'b000);
    localparam logic [CNT_W-1:0] CNT_BAD    = '1;

    // last phase index for the write setup count; the prohibited code runs 15 clocks
    function automatic logic [CNT_W-1:0] wsetup_last(input logic [CNT_W-1:0] f);
        return (f == CNT_BAD) ? CNT_BAD - 1'b1 : f;
    endfunction

    function automatic logic setup_bad(input timing_t t);
        return t.w_setup == CNT_BAD;
    endfunction

endpackage

// File: rtl/smc_cfg_latch.sv
module smc_cfg_latch
    import smc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] timing_in,
    input  logic [2:0]  mode_in,
    output timing_t     tim_q,
    output mode_t       mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q  <= TIMING_RST;
            mode_q <= MODE_RST;
        end else if (load) begin
            tim_q  <= timing_t'(timing_in);
            mode_q <= mode_t'(mode_in);
        end
    end

endmodule

// File: rtl/smc_page_track.sv
module smc_page_track #(
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_write,
    input  logic             start_page,
    input  logic [TAG_W-1:0] start_tag,
    output logic             hit_q
);

    logic             open_q;
    logic [TAG_W-1:0] tag_q;
    logic             page_rd;

    assign page_rd = start_page && !start_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            tag_q  <= '0;
            hit_q  <= 1'b0;
        end else if (start) begin
            hit_q  <= page_rd && open_q && (tag_q == start_tag);
            open_q <= page_rd;
            tag_q  <= start_tag;
        end
    end

endmodule

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
    import smc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_direct,
    input  timing_t          tim,
    input  logic             page_mode,
    input  logic             write_q,
    input  logic             hit_q,
    output phase_e           phase,
    output logic             ready,
    output logic             acc_last,
    output logic             we_win,
    output logic             done
);

    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] last;
    logic             phase_end;

    always_comb begin
        case (phase)
            PH_SETUP:  last = write_q ? wsetup_last(tim.w_setup) : tim.r_setup;
            PH_ACCESS: begin
                if (write_q)        last = tim.w_acc;
                else if (page_mode) last = hit_q ? tim.r_acc : tim.r_first;
                else                last = tim.r_acc;
            end
            PH_GAP:    last = write_q ? tim.w_idle : tim.r_idle;
            default:   last = '0;
        endcase
    end

    assign phase_end = (idx == last);
    assign ready     = (phase == PH_IDLE);
    assign acc_last  = (phase == PH_ACCESS) && phase_end;
    assign we_win    = (phase == PH_ACCESS) && write_q && (idx <= tim.w_we);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= acc_last;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= start_direct ? PH_ACCESS : PH_SETUP;
                        idx   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (phase_end) begin
                        phase <= PH_ACCESS;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_ACCESS: begin
                    if (phase_end) begin
                        phase <= PH_GAP;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (phase_end) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/smc_pin_drv.sv
module smc_pin_drv
    import smc_pkg::*;
#(
    parameter int BW = 2
) (
    input  phase_e        phase,
    input  logic          write_q,
    input  logic          rd_mask,
    input  logic          we_off,
    input  logic          we_win,
    input  logic [BW-1:0] be_q,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic [BW-1:0] bm_n,
    output logic          data_oe
);

    always_comb begin
        cs_n    = 1'b1;
        oe_n    = 1'b1;
        we_n    = 1'b1;
        bm_n    = '1;
        data_oe = 1'b0;
        case (phase)
            PH_SETUP: begin
                cs_n    = 1'b0;
                data_oe = write_q;
            end
            PH_ACCESS: begin
                cs_n = 1'b0;
                if (write_q) begin
                    data_oe = 1'b1;
                    if (we_off) begin
                        if (we_win) bm_n = ~be_q;
                    end else begin
                        we_n = !we_win;
                        bm_n = ~be_q;
                    end
                end else begin
                    oe_n = 1'b0;
                    if (rd_mask) bm_n = ~be_q;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/smc_engine.sv
module smc_engine
    import smc_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DW     = 16,
    parameter int BW     = DW / 8,
    parameter int PAGE_W = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   cfg_timing,
    input  logic [2:0]    cfg_mode,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          cfg_err,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wdata_oe,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [BW-1:0] mem_bm_n
);

    localparam int TAG_W = AW - PAGE_W;

    timing_t       tim_q;
    mode_t         mode_q;
    timing_t       tim_live;
    mode_t         mode_live;
    phase_e        phase;
    logic          start;
    logic          start_direct;
    logic          hit_q;
    logic          acc_last;
    logic          we_win;
    logic          write_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [BW-1:0] be_q;
    logic [DW-1:0] rd_q;
    logic          err_q;

    assign tim_live     = timing_t'(cfg_timing);
    assign mode_live    = mode_t'(cfg_mode);
    assign start        = req_ready && req_valid;
    assign start_direct = !req_write && mode_live.page;

    smc_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .timing_in (cfg_timing),
        .mode_in   (cfg_mode),
        .tim_q     (tim_q),
        .mode_q    (mode_q)
    );

    smc_page_track #(.TAG_W(TAG_W)) u_page (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (req_write),
        .start_page  (mode_live.page),
        .start_tag   (req_addr[AW-1:PAGE_W]),
        .hit_q       (hit_q)
    );

    smc_phase_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_direct (start_direct),
        .tim          (tim_q),
        .page_mode    (mode_q.page),
        .write_q      (write_q),
        .hit_q        (hit_q),
        .phase        (phase),
        .ready        (req_ready),
        .acc_last     (acc_last),
        .we_win       (we_win),
        .done         (done)
    );

    smc_pin_drv #(.BW(BW)) u_pins (
        .phase   (phase),
        .write_q (write_q),
        .rd_mask (mode_q.rd_mask),
        .we_off  (mode_q.we_off),
        .we_win  (we_win),
        .be_q    (be_q),
        .cs_n    (mem_cs_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .bm_n    (mem_bm_n),
        .data_oe (mem_wdata_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rd_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            if (start) begin
                write_q <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                if (req_write && setup_bad(tim_live)) err_q <= 1'b1;
            end
            if (acc_last && !write_q) rd_q <= mem_rdata;
        end
    end

    assign rd_data   = rd_q;
    assign cfg_err   = err_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/smc_engine_chk.sv
module smc_engine_chk
    import smc_pkg::*;
#(
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          done,
    input logic          cfg_err,
    input logic          mem_cs_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [BW-1:0] mem_bm_n,
    input timing_t       tim_q,
    input mode_t         mode_q
);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_strobe_in_cs_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

    assert_ready_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && (&mem_bm_n)));

    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_we_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && mode_q.we_off) |-> mem_we_n);

    assert_rd_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n && !mode_q.rd_mask) |-> (&mem_bm_n));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> ($stable(tim_q) && $stable(mode_q)));

endmodule

bind smc_engine smc_engine_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .cfg_err   (cfg_err),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bm_n  (mem_bm_n),
    .tim_q     (tim_q),
    .mode_q    (mode_q)
);

// File: tb/sim_smc_engine.sv
`timescale 1ns/1ps
module sim_smc_engine;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   cfg_timing;
    logic [2:0]    cfg_mode;
    logic          req_valid;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [BW-1:0] req_be;
    logic          req_ready;
    logic          done;
    logic [DW-1:0] rd_data;
    logic          cfg_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic [DW-1:0] mem_rdata;
    logic          mem_cs_n;
    logic          mem_oe_n;
    logic          mem_we_n;
    logic [BW-1:0] mem_bm_n;

    always #2 clk = ~clk;

    smc_engine #(.AW(AW), .DW(DW), .BW(BW), .PAGE_W(PW)) u0 (
        .clk(clk), .rst(rst), .cfg_timing(cfg_timing), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .cfg_err(cfg_err),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bm_n(mem_bm_n)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (DW'(a) * 16'd7) ^ 16'h3C5A;
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    typedef struct {
        logic          cs, oe, we, doe, done, rdv, err;
        logic [BW-1:0] bm;
        logic [DW-1:0] rd, wd;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    bit   noise = 0;
    bit   err_m = 0;
    bit   open_m = 0;
    logic [AW-PW-1:0] tag_m = '0;

    bit            have_pend = 0;
    bit            p_wr, p_nz;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wd;
    logic [BW-1:0] p_be;
    logic [31:0]   p_tim;
    logic [2:0]    p_mode;
    string         p_tag;

    function automatic logic [31:0] mk(int wi, int wwe, int ws, int wa,
                                       int ri, int rf, int rs, int ra);
        return {4'(wi), 4'(wwe), 4'(ws), 4'(wa), 4'(ri), 4'(rf), 4'(rs), 4'(ra)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t quiet(string tag);
        exp_t e;
        e.cs = 1; e.oe = 1; e.we = 1; e.doe = 0; e.done = 0; e.rdv = 0;
        e.err = err_m; e.bm = '1; e.rd = '0; e.wd = p_wd; e.addr = p_addr;
        e.tag = tag;
        return e;
    endfunction

    task automatic push_e(exp_t e);
        if (p_tag.len() != 0) e.tag = p_tag;
        q.push_back(e);
    endtask

    task automatic build();
        int ws, wa, wwe, wi, ri, rf, rs, ra, ns, na;
        bit hit;
        exp_t e;
        wi = int'(p_tim[31:28]); wwe = int'(p_tim[27:24]);
        ws = int'(p_tim[23:20]); wa  = int'(p_tim[19:16]);
        ri = int'(p_tim[15:12]); rf  = int'(p_tim[11:8]);
        rs = int'(p_tim[7:4]);   ra  = int'(p_tim[3:0]);
        if (p_wr && ws == 15) err_m = 1;
        if (p_wr) begin
            ns = (ws == 15) ? 15 : ws + 1;
            for (int i = 0; i < ns; i++) begin
                e = quiet((ws == 15) ? "R4" : "R3");
                e.cs = 0; e.doe = 1;
                push_e(e);
            end
            for (int i = 0; i < wa + 1; i++) begin
                bit win;
                win = (i <= wwe);
                e = quiet("R8");
                e.cs = 0; e.doe = 1;
                if (p_mode[1]) begin
                    e.tag = "R7";
                    e.bm  = win ? ~p_be : '1;
                end else begin
                    e.we = !win;
                    e.bm = ~p_be;
                    if (!win) e.tag = "R3";
                end
                push_e(e);
            end
            for (int i = 0; i < wi + 1; i++) begin
                e = quiet((i == 0) ? "R10" : "R5");
                e.done = (i == 0);
                push_e(e);
            end
            open_m = 0;
        end else begin
            if (p_mode[0]) begin
                hit    = open_m && (tag_m == p_addr[AW-1:PW]);
                na     = hit ? ra + 1 : rf + 1;
                open_m = 1;
                tag_m  = p_addr[AW-1:PW];
            end else begin
                for (int i = 0; i < rs + 1; i++) begin
                    e = quiet("R2");
                    e.cs = 0;
                    push_e(e);
                end
                na     = ra + 1;
                open_m = 0;
            end
            for (int i = 0; i < na; i++) begin
                e = quiet(p_mode[2] ? "R9" : (p_mode[0] ? "R6" : "R2"));
                e.cs = 0; e.oe = 0;
                if (p_mode[2]) e.bm = ~p_be;
                push_e(e);
            end
            for (int i = 0; i < ri + 1; i++) begin
                e = quiet((i == 0) ? "R10" : "R5");
                e.done = (i == 0);
                e.rdv  = (i == 0);
                e.rd   = mem_word(p_addr);
                push_e(e);
            end
        end
    endtask

    task automatic step();
        bit   idle_now;
        exp_t e;
        @(negedge clk);
        idle_now = (q.size() == 0);
        if (idle_now) e = quiet("R5");
        else e = q.pop_front();
        chk(e.tag, "ready", 32'(req_ready), 32'(idle_now));
        chk(e.tag, "cs_n", 32'(mem_cs_n), 32'(e.cs));
        chk(e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe));
        chk(e.tag, "we_n", 32'(mem_we_n), 32'(e.we));
        chk(e.tag, "bm_n", 32'(mem_bm_n), 32'(e.bm));
        chk(e.tag, "data_oe", 32'(mem_wdata_oe), 32'(e.doe));
        chk(e.tag, "done", 32'(done), 32'(e.done));
        chk("R4", "cfg_err", 32'(cfg_err), 32'(e.err));
        if (!e.cs) chk(e.tag, "addr", 32'(mem_addr), 32'(e.addr));
        if (e.doe) chk(e.tag, "wdata", 32'(mem_wdata), 32'(e.wd));
        if (e.rdv) chk("R10", "rd_data", 32'(rd_data), 32'(e.rd));
        req_valid = 1'b0;
        if (idle_now && have_pend) begin
            req_valid  = 1'b1;
            req_write  = p_wr;
            req_addr   = p_addr;
            req_wdata  = p_wd;
            req_be     = p_be;
            cfg_timing = p_tim;
            cfg_mode   = p_mode;
            build();
            have_pend  = 0;
            noise      = p_nz;
        end else if (!idle_now && noise) begin
            // R11 / R5: busy-time requests and config rewrites must change nothing
            req_valid  = 1'b1;
            req_write  = 1'($urandom);
            req_addr   = AW'($urandom);
            req_wdata  = DW'($urandom);
            req_be     = BW'($urandom);
            cfg_timing = $urandom;
            cfg_mode   = 3'($urandom);
        end
    endtask

    task automatic txn(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [BW-1:0] be,
                       logic [31:0] t, logic [2:0] m, string tg, bit nz);
        p_wr = wr; p_addr = a; p_wd = d; p_be = be; p_tim = t; p_mode = m;
        p_tag = tg; p_nz = nz;
        have_pend = 1;
        while (have_pend) step();
    endtask

    initial begin
        logic [31:0] pg;
        cfg_timing = 32'h055F_F00F; cfg_mode = '0;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
        p_wd = '0; p_addr = '0; p_tag = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        chk("R1", "cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1", "oe_n", 32'(mem_oe_n), 32'd1);
        chk("R1", "we_n", 32'(mem_we_n), 32'd1);
        chk("R1", "bm_n", 32'(mem_bm_n), 32'd3);
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "cfg_err", 32'(cfg_err), 32'd0);
        rst = 1'b0;
        step();

        // R2: plain reads, reset-value timing and short timing
        txn(0, 12'h010, '0, 2'b11, 32'h055F_F00F, 3'b000, "", 0);
        txn(0, 12'h123, '0, 2'b01, mk(0, 0, 0, 0, 1, 0, 2, 1), 3'b000, "", 0);
        // R9: byte mask on reads
        txn(0, 12'h124, '0, 2'b10, mk(0, 0, 0, 0, 2, 0, 0, 3), 3'b100, "", 0);
        // R3 / R8: writes, including a window longer than the access phase
        txn(1, 12'h200, 16'hBEEF, 2'b11, 32'h055F_F00F, 3'b000, "", 0);
        txn(1, 12'h201, 16'h1234, 2'b01, mk(1, 7, 0, 2, 0, 0, 0, 0), 3'b000, "", 0);
        // R7: write enable off, mask strobes
        txn(1, 12'h202, 16'h5678, 2'b10, mk(0, 1, 1, 4, 0, 0, 0, 0), 3'b010, "", 0);
        // R4: prohibited setup count
        txn(1, 12'h203, 16'h9ABC, 2'b11, mk(0, 0, 15, 1, 0, 0, 0, 0), 3'b000, "", 0);
        // R6: page reads, hits, misses after write / other page / plain read
        pg = mk(0, 0, 0, 0, 0, 5, 0, 1);
        txn(0, 12'h040, '0, 2'b11, pg, 3'b001, "", 0);
        txn(0, 12'h041, '0, 2'b11, pg, 3'b001, "", 0);
        txn(0, 12'h043, '0, 2'b11, pg, 3'b001, "", 0);
        txn(1, 12'h044, 16'h0F0F, 2'b11, pg, 3'b001, "", 0);
        txn(0, 12'h045, '0, 2'b11, pg, 3'b001, "", 0);
        txn(0, 12'h080, '0, 2'b11, pg, 3'b001, "", 0);
        txn(0, 12'h081, '0, 2'b01, pg, 3'b101, "", 0);
        txn(0, 12'h082, '0, 2'b11, pg, 3'b000, "", 0);
        txn(0, 12'h083, '0, 2'b11, pg, 3'b001, "", 0);
        // R11: config and request noise on every busy clock
        txn(0, 12'h300, '0, 2'b11, mk(2, 1, 3, 2, 2, 1, 3, 2), 3'b000, "R11", 1);
        txn(1, 12'h301, 16'hA5A5, 2'b10, mk(2, 1, 3, 2, 2, 1, 3, 2), 3'b000, "R11", 1);
        txn(0, 12'h302, '0, 2'b01, mk(1, 0, 0, 0, 1, 4, 0, 2), 3'b101, "R11", 1);
        txn(0, 12'h303, '0, 2'b11, mk(1, 0, 0, 0, 1, 4, 0, 2), 3'b101, "R11", 0);
        while (q.size() != 0) step();
        repeat (3) step();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule